// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves one byte at a time over a single data line and generates the matching shift clock on a second line. The clock idles high. Each bit is framed by a low phase and a high phase, and bits go least significant first. In transmit the block drives the data line. In receive it leaves the line undriven and samples it at every rising clock edge.

Software controls the port through four 16-bit registers on a simple write/read port, and three sticky flags are also brought out as pins. Writing the data register while idle starts a transmit. Writing the control register with bit 0 set while idle starts a receive. The baud register sets the phase lengths. Two value ranges select fixed fast timings: 6 cycles per bit, or 4 cycles per bit. Any other value gives a symmetric clock. The baud value is latched when a transfer starts.

The controller has four states:
- ST_IDLE: clock high, data line floating.
- ST_LOW: low phase of a bit.
- ST_HIGH: high phase of a bit.
- ST_TAIL: the one cycle after the last rising edge, with the clock high and the line still driven.

The transitions are:
- start: ST_IDLE to ST_LOW, on an accepted data or control write.
- rise: ST_LOW to ST_HIGH, when the low count ends and bits remain.
- last-rise: ST_LOW to ST_TAIL, when the low count ends on the 8th bit.
- fall: ST_HIGH to ST_LOW, when the high count ends.
- release: ST_TAIL to ST_IDLE, always after one cycle.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, ser_clk is 1, ser_dat_oe is 0, all three flag pins are 0, and reads of the status register (address 3) and the baud register (address 2) return 0.
- R2: A write to the data register (address 0) while idle starts a transmit of wr_data[7:0], least significant bit first. ser_dat_oe goes to 1 on the same edge as the first falling edge. The value of ser_dat at the k-th rising edge (k from 0) equals data bit k.
- R3: With a baud value of 16'h8002 or above, every low phase lasts 4 cycles and every high phase lasts 2 cycles.
- R4: With a baud value of exactly 16'h8001, every low phase lasts 2 cycles and every high phase lasts 2 cycles.
- R5: With a baud value below 16'h8001, both the low phase and the high phase last baud[14:0]+1 cycles.
- R6: ser_dat changes only on the clock edge one cycle after a rising ser_clk edge (or at the start). Its value at each rising edge equals its value in the cycle before that edge.
- R7: One cycle after the 8th rising edge, ser_dat_oe returns to 0 and ser_clk stays 1.
- R8: A write to the control register (address 1) with bit 0 set while idle starts a receive. ser_dat_oe stays 0 throughout, and ser_dat_in is sampled on each of the 8 rising edges, least significant bit first. Afterwards the byte reads from address 0 in bits 7:0, with the upper bits 0.
- R9: Status register (address 3) layout: bit 0 is transmit done, bit 1 is receive done, bit 2 is overrun, bit 3 is busy, and all other bits are 0. The done flag for the transfer sets on the clock edge of the 8th rising edge, so it is visible in the following cycle together with busy = 1.
- R10: A read of the status register (rd_en with rd_addr = 3) clears bits 0 to 2 on that clock edge. A flag set on the same edge wins over the clear.
- R11: A write to the data register while busy is ignored: the byte in flight is unchanged and no further transfer follows. The write sets the overrun flag on that edge.
- R12: The phase lengths are taken from the baud register when a transfer starts. A baud write during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts in these cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 control, 2 baud, 3 status (no effect) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe; a status read clears the flags |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Read data, combinational, 0 when rd_en is low |
| ser_clk | output | 1 | Shift clock, idles high |
| ser_dat | output | 1 | Serial data out |
| ser_dat_oe | output | 1 | Drive enable for the data line |
| ser_dat_in | input | 1 | Serial data in, sampled on rising ser_clk |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The reference point for all timing is the edge that starts the transfer, because ser_clk falls on that same edge. After it, ser_clk rises after exactly the low count and falls after the high count. ser_dat moves one edge after each rise. ser_dat_oe drops one edge after the 8th rise. The flags appear on the edge of the 8th rise.

The bench drives inputs on falling clk edges and samples at falling edges. It therefore counts low-phase and high-phase lengths in whole cycles, and compares ser_dat at each rise with the preceding cycle. It reads status combinationally in the cycle right after the 8th rise, and again one cycle later to see both the float and the clear. Receive data is changed in the cycle after each observed rise, so each bit is held well ahead of the next sampling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_TAIL = 2'd3
    } ssp_state_t;

    // register addresses
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_BAUD = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    // status bit positions
    localparam int SB_TX   = 0;
    localparam int SB_RX   = 1;
    localparam int SB_OV   = 2;
    localparam int SB_BUSY = 3;

endpackage

// File: rtl/ssp_rate.sv
// Maps the baud register value to low- and high-phase lengths in cycles.
module ssp_rate #(
    parameter int             BW        = 16,
    parameter logic [BW-1:0]  FAST6_MIN = 16'h8002,
    parameter logic [BW-1:0]  FAST4_VAL = 16'h8001,
    parameter int             LO6       = 4,
    parameter int             HI6       = 2,
    parameter int             LO4       = 2,
    parameter int             HI4       = 2
) (
    input  logic [BW-1:0] baud,
    output logic [BW-1:0] lo_len,
    output logic [BW-1:0] hi_len
);

    logic [BW-1:0] sym_len;

    // symmetric clock: both phases are the low bits plus one
    assign sym_len = {1'b0, baud[BW-2:0]} + BW'(1);

    always_comb begin
        if (baud >= FAST6_MIN) begin
            lo_len = BW'(LO6);
            hi_len = BW'(HI6);
        end else if (baud == FAST4_VAL) begin
            lo_len = BW'(LO4);
            hi_len = BW'(HI4);
        end else begin
            lo_len = sym_len;
            hi_len = sym_len;
        end
    end

endmodule

// File: rtl/ssp_regs.sv
// Register port: baud storage, start decode, sticky flags, read mux.
module ssp_regs
    import ssp_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_addr,
    input  logic          busy,
    input  logic          fin_tx,
    input  logic          fin_rx,
    input  logic [DW-1:0] rx_byte,
    output logic [BW-1:0] rd_data,
    output logic [BW-1:0] baud_q,
    output logic          start_tx,
    output logic          start_rx,
    output logic          tx_flag,
    output logic          rx_flag,
    output logic          ov_flag
);

    logic wr_dat_sel;
    logic ov_set;
    logic stat_clr;

    assign wr_dat_sel = wr_en && (wr_addr == A_DATA);
    assign start_tx   = wr_dat_sel && !busy;
    assign start_rx   = wr_en && (wr_addr == A_CTRL) && wr_data[0] && !busy;
    assign ov_set     = wr_dat_sel && busy;
    assign stat_clr   = rd_en && (rd_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q <= '0;
        end else if (wr_en && (wr_addr == A_BAUD)) begin
            baud_q <= wr_data;
        end
    end

    // sticky flags: a set on the same edge wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
            ov_flag <= 1'b0;
        end else begin
            tx_flag <= fin_tx || (tx_flag && !stat_clr);
            rx_flag <= fin_rx || (rx_flag && !stat_clr);
            ov_flag <= ov_set || (ov_flag && !stat_clr);
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_addr)
                A_DATA: rd_data = {{(BW-DW){1'b0}}, rx_byte};
                A_CTRL: rd_data = '0;
                A_BAUD: rd_data = baud_q;
                A_STAT: begin
                    rd_data[SB_TX]   = tx_flag;
                    rd_data[SB_RX]   = rx_flag;
                    rd_data[SB_OV]   = ov_flag;
                    rd_data[SB_BUSY] = busy;
                end
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/ssp_engine.sv
// Transfer controller: phase timing, bit counting, shifting, line drive.
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_tx,
    input  logic          start_rx,
    input  logic [DW-1:0] tx_byte,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] hi_len,
    input  logic          ser_in,
    output logic          sclk,
    output logic          sdat,
    output logic          sdat_oe,
    output logic          busy,
    output logic          rx_active,
    output logic          fin_tx,
    output logic          fin_rx,
    output logic [DW-1:0] rx_byte
);

    localparam int BCW = $clog2(DW + 1);

    ssp_state_t     st_q, st_d;
    logic [CW-1:0]  ph_q;
    logic [CW-1:0]  lo_q, hi_q;
    logic [BCW-1:0] bits_q;
    logic [DW-1:0]  sh_q;
    logic           rx_q;
    logic           sclk_q, oe_q, dat_q;
    logic [DW-1:0]  rxb_q;
    logic           ph_end;
    logic           last_bit;
    logic           rise_now;
    logic [DW-1:0]  sh_next;

    assign ph_end   = (ph_q == '0);
    assign last_bit = (bits_q == BCW'(DW - 1));
    assign rise_now = (st_q == ST_LOW) && ph_end;
    assign sh_next  = {ser_in, sh_q[DW-1:1]};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_tx || start_rx) st_d = ST_LOW;
            ST_LOW:  if (ph_end) st_d = last_bit ? ST_TAIL : ST_HIGH;
            ST_HIGH: if (ph_end) st_d = ST_LOW;
            ST_TAIL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath: phase counter, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            bits_q <= '0;
            sh_q   <= '0;
            rx_q   <= 1'b0;
            rxb_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_tx || start_rx) begin
                        lo_q   <= lo_len;
                        hi_q   <= hi_len;
                        ph_q   <= lo_len - CW'(1);
                        bits_q <= '0;
                        rx_q   <= !start_tx;
                        sh_q   <= start_tx ? tx_byte : '0;
                    end
                end
                ST_LOW: begin
                    if (ph_end) begin
                        sh_q   <= sh_next;
                        bits_q <= bits_q + BCW'(1);
                        ph_q   <= hi_q - CW'(1);
                        if (last_bit && rx_q) rxb_q <= sh_next;
                    end else begin
                        ph_q <= ph_q - CW'(1);
                    end
                end
                ST_HIGH: begin
                    if (ph_end) ph_q <= lo_q - CW'(1);
                    else        ph_q <= ph_q - CW'(1);
                end
                ST_TAIL: ph_q <= '0;
                default: ph_q <= '0;
            endcase
        end
    end

    // registered line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            oe_q   <= 1'b0;
            dat_q  <= 1'b0;
        end else begin
            sclk_q <= (st_d != ST_LOW);
            unique case (st_q)
                ST_IDLE: begin
                    if (start_tx) begin
                        oe_q  <= 1'b1;
                        dat_q <= tx_byte[0];
                    end
                end
                ST_HIGH: if (!rx_q) dat_q <= sh_q[0];
                ST_TAIL: oe_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign sclk      = sclk_q;
    assign sdat      = dat_q;
    assign sdat_oe   = oe_q;
    assign busy      = (st_q != ST_IDLE);
    assign rx_active = busy && rx_q;
    assign fin_tx    = rise_now && last_bit && !rx_q;
    assign fin_rx    = rise_now && last_bit && rx_q;
    assign rx_byte   = rxb_q;

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DW = 8,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [1:0]    rd_addr,
    output logic [BW-1:0] rd_data,
    output logic          ser_clk,
    output logic          ser_dat,
    output logic          ser_dat_oe,
    input  logic          ser_dat_in,
    output logic          tx_done,
    output logic          rx_done,
    output logic          overrun
);

    logic [BW-1:0] baud_q;
    logic [BW-1:0] lo_len, hi_len;
    logic          start_tx, start_rx;
    logic          eng_busy, eng_rx;
    logic          fin_tx, fin_rx;
    logic [DW-1:0] rx_byte;

    ssp_regs #(.DW(DW), .BW(BW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .busy     (eng_busy),
        .fin_tx   (fin_tx),
        .fin_rx   (fin_rx),
        .rx_byte  (rx_byte),
        .rd_data  (rd_data),
        .baud_q   (baud_q),
        .start_tx (start_tx),
        .start_rx (start_rx),
        .tx_flag  (tx_done),
        .rx_flag  (rx_done),
        .ov_flag  (overrun)
    );

    ssp_rate #(.BW(BW)) u_rate (
        .baud   (baud_q),
        .lo_len (lo_len),
        .hi_len (hi_len)
    );

    ssp_engine #(.DW(DW), .CW(BW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_tx  (start_tx),
        .start_rx  (start_rx),
        .tx_byte   (wr_data[DW-1:0]),
        .lo_len    (lo_len),
        .hi_len    (hi_len),
        .ser_in    (ser_dat_in),
        .sclk      (ser_clk),
        .sdat      (ser_dat),
        .sdat_oe   (ser_dat_oe),
        .busy      (eng_busy),
        .rx_active (eng_rx),
        .fin_tx    (fin_tx),
        .fin_rx    (fin_rx),
        .rx_byte   (rx_byte)
    );

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk
    import ssp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       rd_en,
    input logic [1:0] rd_addr,
    input logic       ser_clk,
    input logic       ser_dat,
    input logic       ser_dat_oe,
    input logic       tx_done,
    input logic       rx_done,
    input logic       overrun,
    input logic       busy,
    input logic       rx_active
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_clk && !ser_dat_oe));                             // R1

    AST_DAT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));                             // R6

    AST_FLOAT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |=> (!ser_dat_oe && ser_clk));                     // R7

    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> !ser_dat_oe);                                       // R8

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_STAT && !busy) |=> (!tx_done && !rx_done && !overrun)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DATA && busy) |=> overrun);                // R11

endmodule

bind sync_shift_port ssp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .ser_dat_oe (ser_dat_oe),
    .tx_done    (tx_done),
    .rx_done    (rx_done),
    .overrun    (overrun),
    .busy       (eng_busy),
    .rx_active  (eng_rx)
);

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        ser_clk, ser_dat, ser_dat_oe;
    logic        ser_dat_in = 1'b0;
    logic        tx_done, rx_done, overrun;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_dat_oe(ser_dat_oe),
        .ser_dat_in(ser_dat_in), .tx_done(tx_done), .rx_done(rx_done),
        .overrun(overrun)
    );

    // vector: {rx_mode, baud[15:0], byte[7:0]}
    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 16'h8002, 8'hA5},
        {1'b0, 16'h8001, 8'h3C},
        {1'b0, 16'hFFFF, 8'h01},
        {1'b0, 16'h0002, 8'h80},
        {1'b1, 16'h8002, 8'h5A},
        {1'b1, 16'h8001, 8'hC3},
        {1'b0, 16'h8000, 8'h7E},
        {1'b1, 16'h0000, 8'h96}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_lo(input logic [15:0] b);
        if (b >= 16'h8002) return 4;
        if (b == 16'h8001) return 2;
        return int'(b[14:0]) + 1;
    endfunction

    function automatic int exp_hi(input logic [15:0] b);
        if (b >= 16'h8002) return 2;
        if (b == 16'h8001) return 2;
        return int'(b[14:0]) + 1;
    endfunction

    function automatic string rate_tag(input logic [15:0] b);
        if (b >= 16'h8002) return "R3 low/high phase";
        if (b == 16'h8001) return "R4 low/high phase";
        return "R5 low/high phase";
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // inj: 0 none, 1 data write at 3rd rise, 2 baud write at 3rd rise
    task automatic run_xfer(input bit rxm, input logic [15:0] baud,
                            input logic [7:0] data, input int inj);
        logic [15:0] st;
        logic [7:0]  got = '0;
        int  rises = 0, lo_cnt = 0, hi_cnt = 0;
        int  lo_bad = 0, hi_bad = 0, stab_bad = 0, drv_bad = 0;
        int  guard = 0;
        logic prev_s = 1'b1, prev_d;
        int  elo = exp_lo(baud), ehi = exp_hi(baud);
        wr(2'd2, baud);
        rd(2'd3, st);                 // clear flags from earlier runs
        ser_dat_in = data[0];
        if (rxm) wr(2'd1, 16'h0001); else wr(2'd0, {8'h00, data});
        prev_d = ser_dat;
        while (rises < 8 && guard < 4000) begin
            guard++;
            wr_en = 1'b0;
            if (rxm && ser_dat_oe) drv_bad++;
            if (!ser_clk) begin
                if (prev_s && rises > 0 && hi_cnt != ehi) hi_bad++;
                lo_cnt++;
            end else if (!prev_s) begin
                if (lo_cnt != elo) lo_bad++;
                if (!rxm) begin
                    got[rises] = ser_dat;
                    if (ser_dat != prev_d) stab_bad++;
                end
                rises++;
                lo_cnt = 0;
                hi_cnt = 1;
                if (rxm && rises < 8) ser_dat_in = data[rises];
                if (rises == 3 && inj == 1) begin
                    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h00EE;
                end
                if (rises == 3 && inj == 2) begin
                    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0005;
                end
            end else begin
                hi_cnt++;
            end
            prev_s = ser_clk;
            prev_d = ser_dat;
            if (rises < 8) @(negedge clk);
        end
        chk(rises == 8, "R2 eight rising edges", rises, 8);
        if (rxm) chk(drv_bad == 0, "R8 line undriven in receive", drv_bad, 0);
        else begin
            chk(got == data, "R2 bits at rising edges", got, data);
            chk(stab_bad == 0, "R6 data stable into rise", stab_bad, 0);
        end
        chk(lo_bad == 0, rate_tag(baud), lo_bad, 0);
        chk(hi_bad == 0, rate_tag(baud), hi_bad, 0);
        // cycle after the 8th rise: flags visible, line still driven on transmit
        chk(ser_dat_oe == !rxm, "R7 line driven in tail cycle", ser_dat_oe, !rxm);
        rd_en = 1'b1; rd_addr = 2'd3;
        #1 st = rd_data;
        chk(st == {12'd0, 1'b1, (inj == 1), rxm, !rxm}, "R9 status after last rise",
            st, {12'd0, 1'b1, (inj == 1), rxm, !rxm});
        @(negedge clk);
        rd_en = 1'b0;
        chk(ser_dat_oe == 1'b0 && ser_clk == 1'b1, "R7 float and clock high",
            {ser_dat_oe, ser_clk}, 2'b01);
        rd(2'd3, st);
        chk(st == 16'd0, "R10 flags cleared by status read", st, 0);
        if (rxm) begin
            rd(2'd0, st);
            chk(st == {8'h00, data}, "R8 received byte", st, data);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] st;
        int hi_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ser_clk == 1'b1 && ser_dat_oe == 1'b0, "R1 line idle after reset",
            {ser_clk, ser_dat_oe}, 2'b10);
        chk({tx_done, rx_done, overrun} == 3'b000, "R1 flag pins after reset",
            {tx_done, rx_done, overrun}, 0);
        rd(2'd3, st);
        chk(st == 16'd0, "R1 status after reset", st, 0);
        rd(2'd2, st);
        chk(st == 16'd0, "R1 baud after reset", st, 0);

        for (int i = 0; i < NV; i++) begin
            run_xfer(VEC[i][24], VEC[i][23:8], VEC[i][7:0], 0);
            repeat (2) @(negedge clk);
        end

        // R11: data write during a transfer is ignored and flags overrun
        run_xfer(1'b0, 16'h8002, 8'h11, 1);
        hi_seen = 0;
        for (int c = 0; c < 30; c++) begin
            if (ser_clk && !ser_dat_oe) hi_seen++;
            @(negedge clk);
        end
        chk(hi_seen == 30, "R11 no transfer after ignored write", hi_seen, 30);

        // R12: baud write mid-transfer does not change the transfer in flight
        run_xfer(1'b0, 16'h8001, 8'hB4, 2);
        rd(2'd2, st);
        chk(st == 16'h0005, "R12 baud register took the new value", st, 16'h0005);

        // R5 with the new baud (5 -> 6 cycles per phase), receive
        run_xfer(1'b1, 16'h0005, 8'h69, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule